// File: doc/BRIEF.md
# Output Word Formatter

This block assembles the 22-bit word that a converter's serial port shifts out during a frame. On every capture strobe (the cycle in which chip select falls) it registers a new word. The upper 20 bits carry one of three payloads: the most recent conversion result, a programmed 20-bit test pattern, or an 8-bit register readback that the command decoder requested during the previous frame. The two low bits are an optional even-parity tail.

A readback request is a one-cycle strobe from the command decoder. It carries the register contents and is held internally until the next capture. That capture consumes it, so the readback appears in exactly one frame. Conversion results arrive with their own valid strobe and are held until replaced. The registered word does not change between captures, whatever happens on the inputs.

Top module: `out_word_fmt`

## Requirements
- R1: After reset, and after any later reset, `word_o` is zero, no readback is pending, and the held conversion result is zero. A capture with pattern and parity off then yields an all-zero word.
- R2: `word_o` changes only in the cycle after `cs_fall_i` is high. Between captures it holds its value even when the result, the pattern or the controls change.
- R3: With no pending readback and `patn_en_i` low, `word_o[21:2]` is the most recent conversion result, unchanged, in two's complement (80000h is negative full scale, 7FFFFh is positive full scale).
- R4: If `conv_valid_i` and `cs_fall_i` are high in the same cycle, the capture uses the new `conv_data_i`.
- R5: With no pending readback and `patn_en_i` high, `word_o[21:2]` is `{patn_hi_i, patn_mid_i, patn_lo_i}`.
- R6: A `rd_req_i` strobe before a capture makes that capture place `rd_data_i` in `word_o[21:14]` and zeros in `word_o[13:2]`. This takes priority over the pattern and the result. The following capture no longer uses it.
- R7: A `rd_req_i` strobe in the same cycle as `cs_fall_i` does not affect that capture. It applies to the next capture.
- R8: With `par_en_i` low, `word_o[1:0]` is 00.
- R9: With `par_en_i` high, `word_o[1]` is the XOR of `word_o[21:2]`, so the payload plus that bit holds an even number of ones.
- R10: With `par_en_i` high, `word_o[0]` is the XOR of the top 4, 8, 12 or 16 payload bits (`word_o[21:18]`, `[21:14]`, `[21:10]`, `[21:6]`) for `par_span_i` = 0, 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_valid_i | input | 1 | New conversion result strobe |
| conv_data_i | input | 20 | Conversion result, two's complement |
| patn_en_i | input | 1 | Replace the result with the test pattern |
| patn_hi_i | input | 4 | Pattern bits 19:16 |
| patn_mid_i | input | 8 | Pattern bits 15:8 |
| patn_lo_i | input | 8 | Pattern bits 7:0 |
| par_en_i | input | 1 | Enable the parity tail |
| par_span_i | input | 2 | Leading-bit span of the short parity |
| rd_req_i | input | 1 | Readback request for the next frame |
| rd_data_i | input | 8 | Register contents to read back |
| cs_fall_i | input | 1 | Capture strobe, chip-select falling edge |
| word_o | output | 22 | Registered output word |

## Verification
The hardest situations to reach are the same-cycle collisions. In one, a readback request lands on the capture strobe. In the other, a new result strobe lands on the capture strobe. Both decide which frame a value belongs to, and a design with an off-by-one-frame error would still look correct under ordinary spaced stimulus. The bench drives both strobes on the same falling clock edge. It then checks two consecutive captures, confirming that the collided readback skips the current word and appears only in the next one. It also checks that a collided result does appear at once.

// File: rtl/owf_pkg.sv
package owf_pkg;
  localparam int PAY_W      = 20;
  localparam int REG_W      = 8;
  localparam int TAIL_W     = 2;
  localparam int WORD_W     = PAY_W + TAIL_W;
  localparam int PAT_HI_W   = PAY_W - 2 * REG_W;
  localparam int SPAN_STEP  = 4;
  localparam int SPAN_SEL_W = 2;

  typedef enum logic [1:0] {
    SRC_CONV = 2'd0,
    SRC_PATN = 2'd1,
    SRC_READ = 2'd2
  } src_e;
endpackage

// File: rtl/owf_result_hold.sv
module owf_result_hold #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] cur_o
);
  logic [W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_q <= '0;
    else if (valid_i) res_q <= data_i;
  end

  // same-cycle strobe forwards straight into the capture
  assign cur_o = valid_i ? data_i : res_q;
endmodule

// File: rtl/owf_readback_hold.sv
module owf_readback_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  output logic         pend_o,
  output logic [W-1:0] data_o
);
  logic         pend_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (req_i)       pend_q <= 1'b1;
      else if (take_i) pend_q <= 1'b0;
      if (req_i)       data_q <= data_i;
    end
  end

  assign pend_o = pend_q;
  assign data_o = data_q;
endmodule

// File: rtl/owf_parity.sv
module owf_parity #(
  parameter int PAY_W      = 20,
  parameter int SPAN_STEP  = 4,
  parameter int SPAN_SEL_W = 2
) (
  input  logic [PAY_W-1:0]      payload_i,
  input  logic                  en_i,
  input  logic [SPAN_SEL_W-1:0] sel_i,
  output logic [1:0]            tail_o
);
  localparam int NSPAN = 1 << SPAN_SEL_W;

  logic [NSPAN-1:0] lead_par;

  for (genvar k = 0; k < NSPAN; k++) begin : g_span
    assign lead_par[k] = ^payload_i[PAY_W-1 -: SPAN_STEP*(k+1)];
  end

  assign tail_o = en_i ? {^payload_i, lead_par[sel_i]} : 2'b00;
endmodule

// File: rtl/out_word_fmt.sv
module out_word_fmt
  import owf_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  conv_valid_i,
  input  logic [PAY_W-1:0]      conv_data_i,
  input  logic                  patn_en_i,
  input  logic [PAT_HI_W-1:0]   patn_hi_i,
  input  logic [REG_W-1:0]      patn_mid_i,
  input  logic [REG_W-1:0]      patn_lo_i,
  input  logic                  par_en_i,
  input  logic [SPAN_SEL_W-1:0] par_span_i,
  input  logic                  rd_req_i,
  input  logic [REG_W-1:0]      rd_data_i,
  input  logic                  cs_fall_i,
  output logic [WORD_W-1:0]     word_o
);
  logic [PAY_W-1:0]  conv_cur;
  logic              rd_pend_q;
  logic [REG_W-1:0]  rd_val;
  src_e              src;
  logic [PAY_W-1:0]  payload;
  logic [TAIL_W-1:0] tail;
  logic [WORD_W-1:0] word_q;

  owf_result_hold #(.W(PAY_W)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (conv_valid_i),
    .data_i  (conv_data_i),
    .cur_o   (conv_cur)
  );

  owf_readback_hold #(.W(REG_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (rd_req_i),
    .data_i (rd_data_i),
    .take_i (cs_fall_i),
    .pend_o (rd_pend_q),
    .data_o (rd_val)
  );

  always_comb begin
    if (rd_pend_q)      src = SRC_READ;
    else if (patn_en_i) src = SRC_PATN;
    else                src = SRC_CONV;
  end

  always_comb begin
    unique case (src)
      SRC_READ: payload = {rd_val, {(PAY_W-REG_W){1'b0}}};
      SRC_PATN: payload = {patn_hi_i, patn_mid_i, patn_lo_i};
      default:  payload = conv_cur;
    endcase
  end

  owf_parity #(
    .PAY_W      (PAY_W),
    .SPAN_STEP  (SPAN_STEP),
    .SPAN_SEL_W (SPAN_SEL_W)
  ) u_par (
    .payload_i (payload),
    .en_i      (par_en_i),
    .sel_i     (par_span_i),
    .tail_o    (tail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        word_q <= '0;
    else if (cs_fall_i) word_q <= {payload, tail};
  end

  assign word_o = word_q;
endmodule

// File: rtl/owf_checker.sv
module owf_checker
  import owf_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_fall_i,
  input logic                rd_req_i,
  input logic                patn_en_i,
  input logic                par_en_i,
  input logic [PAT_HI_W-1:0] patn_hi_i,
  input logic [REG_W-1:0]    patn_mid_i,
  input logic [REG_W-1:0]    patn_lo_i,
  input logic                rd_pend_q,
  input logic [WORD_W-1:0]   word_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_zero: assert (word_o == '0);
  end

  a_r2_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall_i |=> $stable(word_o));

  a_r5_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i && !rd_pend_q && patn_en_i |=>
      word_o[WORD_W-1:TAIL_W] == $past({patn_hi_i, patn_mid_i, patn_lo_i}));

  a_r6_read_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i && rd_pend_q |=> word_o[WORD_W-REG_W-1:TAIL_W] == '0);

  a_r6_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i && !rd_req_i |=> !rd_pend_q);

  a_r8_tail_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i && !par_en_i |=> word_o[TAIL_W-1:0] == '0);

  a_r9_full_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i && par_en_i |=> (^word_o[WORD_W-1:1]) == 1'b0);
endmodule

bind out_word_fmt owf_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_fall_i  (cs_fall_i),
  .rd_req_i   (rd_req_i),
  .patn_en_i  (patn_en_i),
  .par_en_i   (par_en_i),
  .patn_hi_i  (patn_hi_i),
  .patn_mid_i (patn_mid_i),
  .patn_lo_i  (patn_lo_i),
  .rd_pend_q  (rd_pend_q),
  .word_o     (word_o)
);

// File: tb/out_word_fmt_tb_top.sv
module out_word_fmt_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        conv_valid_i = 1'b0;
  logic [19:0] conv_data_i = '0;
  logic        patn_en_i = 1'b0;
  logic [3:0]  patn_hi_i = '0;
  logic [7:0]  patn_mid_i = '0;
  logic [7:0]  patn_lo_i = '0;
  logic        par_en_i = 1'b0;
  logic [1:0]  par_span_i = '0;
  logic        rd_req_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic        cs_fall_i = 1'b0;
  logic [21:0] word_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  out_word_fmt dut_i (
    .clk_i, .rst_ni, .conv_valid_i, .conv_data_i, .patn_en_i,
    .patn_hi_i, .patn_mid_i, .patn_lo_i, .par_en_i, .par_span_i,
    .rd_req_i, .rd_data_i, .cs_fall_i, .word_o
  );

  typedef struct packed {
    logic [19:0] conv;
    logic [19:0] patn;
    logic        pe;
    logic        par;
    logic [1:0]  sel;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{20'h80000, 20'h00000, 1'b0, 1'b0, 2'd0},
    '{20'h7FFFF, 20'h00000, 1'b0, 1'b1, 2'd0},
    '{20'hFFFFF, 20'h00000, 1'b0, 1'b1, 2'd1},
    '{20'h00001, 20'hA5C3E, 1'b1, 1'b1, 2'd2},
    '{20'h12345, 20'h0F0F1, 1'b1, 1'b1, 2'd3},
    '{20'h5A5A5, 20'h00000, 1'b0, 1'b1, 2'd3},
    '{20'h00000, 20'h00000, 1'b0, 1'b1, 2'd0},
    '{20'h3C3C3, 20'hFFFFF, 1'b1, 1'b0, 2'd0}
  };

  function automatic logic [21:0] exp_word(logic [19:0] p, logic pen, logic [1:0] sel);
    logic [19:0] lead;
    lead = p >> (20 - 4 * (int'(sel) + 1));
    return pen ? {p, ^p, ^lead} : {p, 2'b00};
  endfunction

  task automatic check(string req, logic [21:0] act, logic [21:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic conv_strobe(logic [19:0] d);
    @(negedge clk_i); conv_valid_i = 1'b1; conv_data_i = d;
    @(negedge clk_i); conv_valid_i = 1'b0;
  endtask

  task automatic capture();
    @(negedge clk_i); cs_fall_i = 1'b1;
    @(negedge clk_i); cs_fall_i = 1'b0;
  endtask

  task automatic rd_request(logic [7:0] d);
    @(negedge clk_i); rd_req_i = 1'b1; rd_data_i = d;
    @(negedge clk_i); rd_req_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset word", word_o, 22'h0);
    rst_ni = 1'b1;
    capture();
    check("R1 held result zero", word_o, 22'h0);

    for (int i = 0; i < 8; i++) begin
      logic [19:0] pay;
      patn_hi_i  = VEC[i].patn[19:16];
      patn_mid_i = VEC[i].patn[15:8];
      patn_lo_i  = VEC[i].patn[7:0];
      patn_en_i  = VEC[i].pe;
      par_en_i   = VEC[i].par;
      par_span_i = VEC[i].sel;
      conv_strobe(VEC[i].conv);
      capture();
      pay = VEC[i].pe ? VEC[i].patn : VEC[i].conv;
      check(!VEC[i].par ? (VEC[i].pe ? "R5 R8" : "R3 R8")
                        : (VEC[i].pe ? "R5 R9 R10" : "R3 R9 R10"),
            word_o, exp_word(pay, VEC[i].par, VEC[i].sel));
    end

    // R2: no capture, inputs churn, word holds
    patn_en_i = 1'b0; par_en_i = 1'b1; par_span_i = 2'd1;
    conv_strobe(20'h13579);
    capture();
    check("R3 R10 span8", word_o, exp_word(20'h13579, 1'b1, 2'd1));
    conv_strobe(20'h2468A);
    patn_en_i = 1'b1; patn_hi_i = 4'h9; patn_mid_i = 8'h99; patn_lo_i = 8'h99;
    par_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R2 hold", word_o, exp_word(20'h13579, 1'b1, 2'd1));

    // R4: result strobe collides with capture
    patn_en_i = 1'b0; par_en_i = 1'b1; par_span_i = 2'd2;
    @(negedge clk_i);
    conv_valid_i = 1'b1; conv_data_i = 20'hABCDE; cs_fall_i = 1'b1;
    @(negedge clk_i);
    conv_valid_i = 1'b0; cs_fall_i = 1'b0;
    check("R4 forward", word_o, exp_word(20'hABCDE, 1'b1, 2'd2));

    // R6: readback beats pattern, then is used once
    patn_en_i = 1'b1; patn_hi_i = 4'h1; patn_mid_i = 8'h11; patn_lo_i = 8'h11;
    par_span_i = 2'd3;
    rd_request(8'hA7);
    capture();
    check("R6 readback", word_o, exp_word({8'hA7, 12'h0}, 1'b1, 2'd3));
    capture();
    check("R6 one shot", word_o, exp_word(20'h11111, 1'b1, 2'd3));

    // R7: readback request collides with capture
    @(negedge clk_i);
    rd_req_i = 1'b1; rd_data_i = 8'h3C; cs_fall_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b0; cs_fall_i = 1'b0;
    check("R7 not this frame", word_o, exp_word(20'h11111, 1'b1, 2'd3));
    capture();
    check("R7 next frame", word_o, exp_word({8'h3C, 12'h0}, 1'b1, 2'd3));

    // R1: reset mid-run clears word, pending readback and held result
    rd_request(8'h55);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid reset word", word_o, 22'h0);
    rst_ni = 1'b1; patn_en_i = 1'b0; par_en_i = 1'b0;
    capture();
    check("R1 mid reset state", word_o, 22'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule